// File: doc/BRIEF.md
# Target Parity Error Reporter

This block sits on the target side of a 32-bit PCI-style bus. It decodes one access at a time with medium decode timing and inserts a configurable number of wait states. It then ends each data phase either with a data transfer (TRDY# asserted) or with a retry (STOP# asserted while TRDY# stays deasserted). Alongside this termination logic it checks bus parity. An address parity error is raised on a flag of its own. A data parity error on write data drives the PERR# pin, which uses an output-enable for tri-state control.

Data parity errors are reported only for phases that really move data. When the master already holds IRDY# during the target's wait states and the write data is bad, the block may report PERR# before it asserts TRDY#. In that case it commits to completing the phase: any retry request that arrives afterwards is refused. A phase that ends in retry never produces PERR#. Address parity is checked on every claimed access, including accesses that are later retried.

Top module: `tgt_parity_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, devsel_n, trdy_n, stop_n and perr_n are high, and perr_oe, addr_perr and status_dpe are low.
- R2: An address phase is a clock where frame_n is low, irdy_n is high and the block is idle. devsel_n goes low on the second clock after the address phase. If ready_req or retry_req is present at the first decision point, exactly WAIT_STATES cycles follow with devsel_n low and trdy_n and stop_n high, and then the phase is terminated.
- R3: If neither request is present at the decision point and no early report has been made, the wait state is extended until a request arrives.
- R4: Parity is even over ad, cbe_n and par, with par sampled one clock after the values it covers. A bad address parity raises addr_perr for exactly one cycle: the cycle after the clock that sampled the address par. This holds whether the access later completes or is retried.
- R5: A command whose cbe_n bit 0 is 1 during the address phase is a write. On a write transfer (irdy_n and trdy_n both low) with bad parity, and without an early report, perr_n is low for one cycle beginning two clocks after the transfer clock.
- R6: perr_n stays high and perr_oe low for read commands, for good write parity, and for any par or ad values driven outside address and data phases.
- R7: With retry_req present at the decision point, stop_n goes low with devsel_n low and trdy_n high, and all three return high on the clock after frame_n is seen high. No data is transferred and perr_n never goes low for that phase, even if bad write parity is detected on the clock of the decision.
- R8: With early reporting enabled, a write whose irdy_n is sampled low during a wait state with bad parity drives perr_n low starting the clock after the par sample. perr_n stays low through the normal report cycle of the transfer that follows.
- R9: Once an early report has been made, the phase is completed with trdy_n low at the first decision point, even if retry_req is asserted.
- R10: After perr_n has been low, it is driven high for exactly one cycle with perr_oe still high, and perr_oe is then released.
- R11: status_dpe is set by every reported data parity error and stays set until a clock where clr_status is high and no new error is reported.
- R12: On the clock after a transfer, trdy_n and devsel_n both return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Access framing from the master, active low |
| irdy_n | input | 1 | Master ready, active low |
| ad | input | AD_W | Multiplexed address and data |
| cbe_n | input | BE_W | Command in the address phase, byte enables in data phases |
| par | input | 1 | Even parity over ad and cbe_n of the previous clock |
| ready_req | input | 1 | Back end asks to complete the current phase |
| retry_req | input | 1 | Back end asks to retry the current phase |
| clr_status | input | 1 | Clears the sticky data parity status |
| devsel_n | output | 1 | Access claimed, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Retry signalling, active low |
| perr_n | output | 1 | Data parity error, active low |
| perr_oe | output | 1 | Drive enable for perr_n |
| addr_perr | output | 1 | One-cycle address parity error pulse |
| status_dpe | output | 1 | Sticky detected data parity error |

## Verification
The bench targets three cases. In the first, the master holds IRDY# through the wait states with bad write data while retry is requested; a design that ignored its own early report would retry a phase it had already flagged. In the second, bad parity becomes known on the decision clock itself; a design that did not suppress reporting once it had chosen retry would pulse PERR# on a phase that moved nothing. It also covers retried accesses with bad address parity, read commands with bad data parity, and random par and ad values while the bus is idle. A design that qualified parity loosely would raise a flag in those cases.

// File: rtl/tpg_pkg.sv
// Shared types for the target parity error reporter.
// Assumes: only one access in flight at a time.
package tpg_pkg;

    // Termination sequencer states
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_DECODE,
        SEQ_WAIT,
        SEQ_DATA,
        SEQ_RETRY
    } seq_state_t;

    // Error pin driver states: released, driving low, driving high before release
    typedef enum logic [1:0] {
        PE_REL,
        PE_LOW,
        PE_HIGH
    } perr_state_t;

endpackage

// File: rtl/tpg_addr_check.sv
// Address parity checker.
// Registers the parity of the address phase bus values. On the next clock it
// compares that parity with par and raises a one-cycle error pulse.
// Assumes: bus_par is the XOR of ad and cbe_n on the current clock.
module tpg_addr_check (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_phase,
    input  logic bus_par,
    input  logic par,
    output logic addr_perr
);

    logic apar_q;
    logic pend_q;

    // Capture address parity and arm the check for the following clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apar_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            apar_q <= bus_par;
            pend_q <= addr_phase;
        end
    end

    // Compare par one clock later and pulse the error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_perr <= 1'b0;
        end else begin
            addr_perr <= pend_q & (par ^ apar_q);
        end
    end

endmodule

// File: rtl/tpg_term_seq.sv
// Termination sequencer.
// Claims each access with medium decode timing, inserts WAIT_STATES wait
// cycles, and then completes the phase with TRDY# or ends it with STOP#
// (retry). A refuse input, raised once parity has been reported early,
// overrides retry and forces completion.
// Assumes: WAIT_STATES >= 1; single data phase per access.
module tpg_term_seq #(
    parameter int WAIT_STATES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic                cmd_wr,
    input  logic                ready_req,
    input  logic                retry_req,
    input  logic                refuse,
    output tpg_pkg::seq_state_t state,
    output logic                addr_phase,
    output logic                is_write,
    output logic                devsel_n,
    output logic                trdy_n,
    output logic                stop_n
);
    import tpg_pkg::*;

    localparam int CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_STATES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             decide;
    logic             xfer;
    logic             abandon;

    // Decode phase qualifiers from the current state and bus
    always_comb begin
        addr_phase = (state == SEQ_IDLE) && !frame_n && irdy_n;
        decide     = (state == SEQ_WAIT) && (cnt_q == CNT_LAST);
        xfer       = (state == SEQ_DATA) && !irdy_n;
        abandon    = frame_n && irdy_n;
    end

    // Advance the sequencer and the wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            cnt_q    <= '0;
            is_write <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (addr_phase) begin
                        state    <= SEQ_DECODE;
                        is_write <= cmd_wr;
                    end
                end
                SEQ_DECODE: begin
                    state <= SEQ_WAIT;
                    cnt_q <= '0;
                end
                SEQ_WAIT: begin
                    if (abandon) begin
                        state <= SEQ_IDLE;
                    end else if (!decide) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (refuse) begin
                        state <= SEQ_DATA;
                    end else if (retry_req) begin
                        state <= SEQ_RETRY;
                    end else if (ready_req) begin
                        state <= SEQ_DATA;
                    end
                end
                SEQ_DATA: begin
                    if (xfer) begin
                        state <= SEQ_IDLE;
                    end
                end
                SEQ_RETRY: begin
                    if (frame_n) begin
                        state <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Drive the target control pins from the state
    always_comb begin
        devsel_n = !((state == SEQ_WAIT) || (state == SEQ_DATA) || (state == SEQ_RETRY));
        trdy_n   = (state != SEQ_DATA);
        stop_n   = (state != SEQ_RETRY);
    end

endmodule

// File: rtl/tpg_perr_ctl.sv
// Data parity checker and PERR# driver.
// Checks write data parity on transfers (normal report, two clocks after the
// transfer) and, if EARLY_EN is set, while the master waits with IRDY#
// during target wait states (early report). An early report sets a
// commitment that makes the sequencer refuse retry. Early reports are
// suppressed once the phase has entered retry.
// Assumes: ad, cbe_n and par stay stable while irdy_n is low.
module tpg_perr_ctl #(
    parameter bit EARLY_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tpg_pkg::seq_state_t state,
    input  logic                is_write,
    input  logic                irdy_n,
    input  logic                trdy_n,
    input  logic                bus_par,
    input  logic                par,
    input  logic                clr_status,
    output logic                refuse,
    output logic                perr_n,
    output logic                perr_oe,
    output logic                status_dpe
);
    import tpg_pkg::*;

    perr_state_t pst_q;
    logic        dpar_q;
    logic        xfer_q;
    logic        early_q;
    logic        committed_q;
    logic        xfer_now;
    logic        mism;
    logic        normal_hit;
    logic        early_hit;
    logic        phase_ok;

    // Identify a write transfer on this clock
    always_comb begin
        xfer_now = is_write && !irdy_n && !trdy_n;
        phase_ok = (state == SEQ_WAIT) || (state == SEQ_DATA);
    end

    // Remember data parity and whether a transfer happened
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpar_q <= 1'b0;
            xfer_q <= 1'b0;
        end else begin
            dpar_q <= bus_par;
            xfer_q <= xfer_now;
        end
    end

    generate
        if (EARLY_EN) begin : g_early
            // Arm an early check while the master waits in a target wait state
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    early_q <= 1'b0;
                end else begin
                    early_q <= is_write && !irdy_n && (state == SEQ_WAIT);
                end
            end
        end else begin : g_no_early
            assign early_q = 1'b0;
        end
    endgenerate

    // Evaluate parity against the delayed par sample
    always_comb begin
        mism       = par ^ dpar_q;
        normal_hit = xfer_q && mism;
        early_hit  = early_q && mism && phase_ok && !committed_q;
        refuse     = committed_q || early_hit;
    end

    // Track the commitment to finish the phase after an early report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            committed_q <= 1'b0;
        end else if ((state == SEQ_IDLE) || xfer_now) begin
            committed_q <= 1'b0;
        end else if (early_hit) begin
            committed_q <= 1'b1;
        end
    end

    // Step the pin driver: low on error, high for one clock, then release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst_q <= PE_REL;
        end else if (normal_hit || early_hit) begin
            pst_q <= PE_LOW;
        end else begin
            case (pst_q)
                PE_LOW:  pst_q <= committed_q ? PE_LOW : PE_HIGH;
                PE_HIGH: pst_q <= PE_REL;
                default: pst_q <= PE_REL;
            endcase
        end
    end

    // Keep the sticky status bit; a new error wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_dpe <= 1'b0;
        end else if (normal_hit || early_hit) begin
            status_dpe <= 1'b1;
        end else if (clr_status) begin
            status_dpe <= 1'b0;
        end
    end

    // Map the driver state onto the pin and its enable
    always_comb begin
        perr_n  = (pst_q != PE_LOW);
        perr_oe = (pst_q != PE_REL);
    end

endmodule

// File: rtl/tgt_parity_guard.sv
// Top: target-side parity checker with termination sequencer.
// Computes bus parity once and shares it between the address checker and
// the data parity reporter. The sequencer decides between completion and
// retry, taking into account whether an early error report has been made.
// Assumes: WAIT_STATES >= 1.
module tgt_parity_guard #(
    parameter int AD_W        = 32,
    parameter int BE_W        = 4,
    parameter int WAIT_STATES = 4,
    parameter bit EARLY_EN    = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe_n,
    input  logic            par,
    input  logic            ready_req,
    input  logic            retry_req,
    input  logic            clr_status,
    output logic            devsel_n,
    output logic            trdy_n,
    output logic            stop_n,
    output logic            perr_n,
    output logic            perr_oe,
    output logic            addr_perr,
    output logic            status_dpe
);
    import tpg_pkg::*;

    seq_state_t state;
    logic       bus_par;
    logic       addr_phase;
    logic       is_write;
    logic       refuse;

    // Even parity contribution of the current ad and cbe_n values
    always_comb begin
        bus_par = ^{ad, cbe_n};
    end

    tpg_addr_check u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_phase (addr_phase),
        .bus_par    (bus_par),
        .par        (par),
        .addr_perr  (addr_perr)
    );

    tpg_term_seq #(
        .WAIT_STATES (WAIT_STATES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .cmd_wr     (cbe_n[0]),
        .ready_req  (ready_req),
        .retry_req  (retry_req),
        .refuse     (refuse),
        .state      (state),
        .addr_phase (addr_phase),
        .is_write   (is_write),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n)
    );

    tpg_perr_ctl #(
        .EARLY_EN (EARLY_EN)
    ) u_perr (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .is_write   (is_write),
        .irdy_n     (irdy_n),
        .trdy_n     (trdy_n),
        .bus_par    (bus_par),
        .par        (par),
        .clr_status (clr_status),
        .refuse     (refuse),
        .perr_n     (perr_n),
        .perr_oe    (perr_oe),
        .status_dpe (status_dpe)
    );

endmodule

// File: rtl/tpg_chk.sv
// Protocol checker bound to the top module. Observes pins only.
module tpg_chk (
    input logic clk,
    input logic rst_n,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic perr_n,
    input logic perr_oe,
    input logic addr_perr,
    input logic status_dpe,
    input logic clr_status
);

    // R7
    stop_trdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> trdy_n);

    // R7
    retry_no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> perr_n);

    // R2
    term_after_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(trdy_n) || $fell(stop_n)) |-> !$past(devsel_n));

    // R10
    perr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> perr_oe);

    // R10
    release_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_oe) |-> ($past(perr_n) && $past(perr_oe)));

    // R4
    aperr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_perr |=> !addr_perr);

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_dpe) |-> $past(clr_status));

    // R12
    trdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trdy_n) |-> $rose(devsel_n));

endmodule

bind tgt_parity_guard tpg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .perr_n     (perr_n),
    .perr_oe    (perr_oe),
    .addr_perr  (addr_perr),
    .status_dpe (status_dpe),
    .clr_status (clr_status)
);

// File: tb/tb_tgt_parity_guard.sv
// Bench for tgt_parity_guard: directed corners plus seeded random accesses.
module tb_tgt_parity_guard;

    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        par = 1'b0;
    logic        ready_req = 1'b0;
    logic        retry_req = 1'b0;
    logic        clr_status = 1'b0;
    logic        devsel_n, trdy_n, stop_n, perr_n, perr_oe, addr_perr, status_dpe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    tgt_parity_guard #(.WAIT_STATES(NW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad(ad), .cbe_n(cbe_n), .par(par), .ready_req(ready_req),
        .retry_req(retry_req), .clr_status(clr_status),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .perr_n(perr_n), .perr_oe(perr_oe), .addr_perr(addr_perr),
        .status_dpe(status_dpe)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic bit in_rng(input int e, input int lo, input int hi);
        return (e >= lo) && (e <= hi);
    endfunction

    function automatic logic even_par(input logic [31:0] a, input logic [3:0] c);
        return ^{a, c};
    endfunction

    // One access; edges numbered from the address phase (edge 0).
    task automatic run_txn(input bit wr, input bit abad, input bit dbad, input bit rty,
                           input int irdy_at, input int rdy_dly);
        logic [31:0] addr = $urandom;
        logic [31:0] data = $urandom;
        logic [3:0]  cmd = wr ? 4'b0111 : 4'b0110;
        logic [3:0]  be = 4'($urandom);
        int d = 1 + NW + rdy_dly;
        int k = imax(irdy_at, 2);
        bit commit = wr && dbad && (k + 1 <= d);
        int d_eff = commit ? imax(1 + NW, k + 1) : d;
        bit is_rty = rty && !commit;
        int t = imax(irdy_at, d_eff + 1);
        bit early = wr && dbad && !is_rty && (k <= d_eff);
        bit report = wr && dbad && !is_rty;
        int lo_start = early ? k + 1 : t + 1;
        int last = is_rty ? d_eff + 2 : t + 4;
        int rnd_from = is_rty ? d_eff + 1 : t + 2;
        string tr_tag = commit ? "R9" : (rdy_dly > 0 ? "R3" : "R2");
        string pe_tag = !report ? (is_rty ? "R7" : "R6") : (early ? "R8" : "R5");
        frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd;
        for (int e = 0; e <= last; e++) begin
            int n = e + 1;
            @(posedge clk);
            @(negedge clk);
            check((e >= t && !is_rty) ? "R12 devsel" : "R2 devsel", 32'(devsel_n),
                  32'(!in_rng(e, 1, is_rty ? d_eff : t - 1)));
            check((e >= t && !is_rty) ? "R12 trdy" : {tr_tag, " trdy"}, 32'(trdy_n),
                  32'(!(!is_rty && in_rng(e, d_eff, t - 1))));
            check("R7 stop", 32'(stop_n), 32'(!(is_rty && e == d_eff)));
            check("R4 addr_perr", 32'(addr_perr), 32'((e == 1) && abad));
            check({pe_tag, " perr_n"}, 32'(perr_n), 32'(!(report && in_rng(e, lo_start, t + 1))));
            check("R10 perr_oe", 32'(perr_oe), 32'(report && in_rng(e, lo_start, t + 2)));
            if (e == last) check("R11 status set", 32'(status_dpe), 32'(report));
            // prepare stimulus for edge n
            if (e == 0) begin
                ad = data; cbe_n = be; par = even_par(addr, cmd) ^ abad;
            end
            if (e == 1) par = even_par(data, be) ^ dbad;
            if (is_rty) begin
                irdy_n  = !(n >= irdy_at && n <= d_eff);
                frame_n = (n >= irdy_at) || (n > d_eff);
            end else begin
                irdy_n  = !(n >= irdy_at && n <= t);
                frame_n = (n >= irdy_at);
            end
            ready_req = !rty && (n == d);
            retry_req = rty && in_rng(n, 1 + NW, d);
            if (n >= rnd_from) begin
                ad = $urandom; cbe_n = 4'($urandom); par = 1'($urandom);
            end
        end
        ready_req = 1'b0; retry_req = 1'b0;
        clr_status = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_status = 1'b0;
        check("R11 status clear", 32'(status_dpe), 32'h0);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 devsel", 32'(devsel_n), 32'h1);
        check("R1 trdy", 32'(trdy_n), 32'h1);
        check("R1 stop", 32'(stop_n), 32'h1);
        check("R1 perr_n", 32'(perr_n), 32'h1);
        check("R1 perr_oe", 32'(perr_oe), 32'h0);
        check("R1 addr_perr", 32'(addr_perr), 32'h0);
        check("R1 status", 32'(status_dpe), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'({devsel_n, trdy_n, stop_n, perr_n, perr_oe}), 32'h1E);
        // directed corners
        run_txn(1, 0, 1, 0, 9, 0);  // R5 normal report
        run_txn(1, 0, 0, 0, 3, 0);  // R6 good write parity
        run_txn(0, 0, 1, 0, 2, 0);  // R6 read with bad parity
        run_txn(1, 0, 1, 0, 2, 2);  // R8 early report, R9 forced completion
        run_txn(1, 0, 1, 1, 3, 0);  // R9 retry refused after early report
        run_txn(1, 0, 1, 1, 5, 0);  // R7 bad parity seen on the decision clock
        run_txn(1, 1, 0, 1, 9, 0);  // R4 address error on a retried access
        run_txn(1, 0, 0, 0, 1, 3);  // R3 wait extension
        run_txn(1, 0, 1, 0, 5, 0);  // R8 early hit landing in the data state
        // seeded random accesses
        for (int i = 0; i < 60; i++) begin
            bit wr = 1'($urandom);
            bit abad = ($urandom % 4) == 0;
            bit dbad = 1'($urandom);
            bit rty = ($urandom % 3) == 0;
            int ia = 1 + int'($urandom % 10);
            int rd = rty ? 0 : int'($urandom % 4);
            run_txn(wr, abad, dbad, rty, ia, rd);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule